// File: doc/BRIEF.md
# Fuse Supply Three-Phase Sequencer

This block switches the programming supply of a fuse array on and off as three timed steps. Software first writes the three 16-bit step delays and then writes a control word. A control word that carries both the enable bit and the begin bit starts power-up. Power-up raises supply stage 0, then stage 1, then stage 2, and each step is followed by its own delay. A control word that carries both the enable bit and the stop bit starts power-down. Power-down drops the stages in the reverse order, 2, 1, 0, and uses the same delays.

Each direction has its own completion flag. Writing an all-zero control field shuts the controller off at once. One down-counter times every step. The delay feeding that counter is picked by the step that is currently active.

Top module: `fuse_supply_seq`

## Requirements
- R1: After reset, `stage_en` is 000, `busy` is 0, `up_done` is 0 and `down_done` is 0.
- R2: The delay words are laid out as follows. Address 0 holds step 0 in bits [15:0] and step 1 in bits [31:16]. Address 1 holds step 2 in bits [15:0], and its bits [31:16] are ignored. Writing address 0 or 1 starts nothing.
- R3: Power-up is started by a write to address 2 with bit 0 (enable) and bit 1 (begin) set while the block is idle. `stage_en[0]` rises in the cycle after the write edge. `stage_en[1]` rises D0+1 cycles later, and `stage_en[2]` rises D1+1 cycles after that. The stages never leave thermometer order.
- R4: Power-up completes D0+D1+D2+3 cycles after the command edge. At that point `up_done` is set, `busy` falls and all three stages are on.
- R5: Power-down is started by a write to address 2 with bit 0 (enable) and bit 2 (stop) set while the block is idle. `stage_en[2]` clears at once. `stage_en[1]` clears D2+1 cycles later, and `stage_en[0]` clears D1+1 cycles after that. `down_done` is set D0+D1+D2+3 cycles after the command edge.
- R6: Accepting either command clears both done flags in the same cycle that the command is taken, so the flags are never set together.
- R7: A control write with bit 0 clear and bit 1 or bit 2 set has no effect. The stages, the flags and `busy` all keep their values.
- R8: A control write whose bits [2:0] are all zero aborts any running sequence and clears both done flags. The stage outputs keep their current values.
- R9: A delay value of zero makes its step last exactly one clock cycle, and a value of N makes the step last N+1 cycles.
- R10: While `busy` is 1, begin and stop commands are ignored. A command with enable, begin and stop all set is treated as begin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 and 1 are delay words, 2 is control |
| wr_data | input | 32 | Write data |
| stage_en | output | 3 | Supply stage enables, bit i drives stage i |
| busy | output | 1 | A sequence is in progress |
| up_done | output | 1 | Power-up sequence has completed |
| down_done | output | 1 | Power-down sequence has completed |

## Verification
The write edge that carries a command is counted as cycle 0, and every output is registered. The first stage change is therefore visible at the sampling point right after that edge. Stage k+1 changes Dk+1 cycles after stage k, and the done flag appears D0+D1+D2+3 cycles after the command. The bench drives and samples on falling edges. After each command it walks cycle by cycle and compares every output against the closed-form step boundaries for that cycle. This also covers writes injected into the middle of a sequence, which must leave the expected timeline unchanged.

// File: rtl/fss_pkg.sv
package fss_pkg;
    // control word bit positions
    localparam int CTL_EN_BIT    = 0;
    localparam int CTL_BEGIN_BIT = 1;
    localparam int CTL_STOP_BIT  = 2;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_UP   = 2'd1,
        MODE_DOWN = 2'd2
    } seq_mode_t;
endpackage

// File: rtl/fss_regs.sv
module fss_regs
    import fss_pkg::*;
#(
    parameter int NUM_PH = 3,
    parameter int DLY_W  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [DATA_W-1:0]              wr_data,
    output logic [NUM_PH-1:0][DLY_W-1:0]   dly,
    output logic                           cmd_up,
    output logic                           cmd_dn,
    output logic                           cmd_off
);
    localparam int PER_WORD  = DATA_W / DLY_W;
    localparam int NUM_WORDS = (NUM_PH + PER_WORD - 1) / PER_WORD;
    localparam int CTRL_ADDR = NUM_WORDS;

    typedef struct packed {
        logic [NUM_PH-1:0][DLY_W-1:0] dly;
    } regs_t;

    regs_t rg_d, rg_q;
    logic  is_ctrl;

    always_comb begin
        rg_d = rg_q;
        for (int p = 0; p < NUM_PH; p++) begin
            if (wr_en && (wr_addr == ADDR_W'(p / PER_WORD))) begin
                rg_d.dly[p] = wr_data[(p % PER_WORD)*DLY_W +: DLY_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    // commands are single-cycle pulses decoded straight from the write
    assign is_ctrl = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
    assign cmd_up  = is_ctrl && wr_data[CTL_EN_BIT] && wr_data[CTL_BEGIN_BIT];
    assign cmd_dn  = is_ctrl && wr_data[CTL_EN_BIT] && wr_data[CTL_STOP_BIT]
                     && !wr_data[CTL_BEGIN_BIT];
    assign cmd_off = is_ctrl && !wr_data[CTL_EN_BIT] && !wr_data[CTL_BEGIN_BIT]
                     && !wr_data[CTL_STOP_BIT];
    assign dly     = rg_q.dly;
endmodule

// File: rtl/fss_timer.sv
module fss_timer #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    output logic             expired
);
    typedef struct packed {
        logic [DLY_W-1:0] cnt;
    } tmr_t;

    tmr_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (load)                  tm_d.cnt = load_val;
        else if (tm_q.cnt != '0)   tm_d.cnt = tm_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign expired = (tm_q.cnt == '0);
endmodule

// File: rtl/fss_fsm.sv
module fss_fsm
    import fss_pkg::*;
#(
    parameter int NUM_PH = 3,
    parameter int PH_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_up,
    input  logic              cmd_dn,
    input  logic              cmd_off,
    input  logic              expired,
    output logic              tmr_load,
    output logic [PH_W-1:0]   tmr_idx,
    output logic [NUM_PH-1:0] stage_en,
    output logic              busy,
    output logic              up_done,
    output logic              down_done
);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(NUM_PH - 1);

    typedef struct packed {
        seq_mode_t         mode;
        logic [PH_W-1:0]   ph;
        logic [NUM_PH-1:0] stg;
        logic              up_done;
        logic              dn_done;
    } fsm_t;

    fsm_t fs_d, fs_q;
    logic [PH_W-1:0] ph_inc, ph_dec;

    assign ph_inc = fs_q.ph + 1'b1;
    assign ph_dec = fs_q.ph - 1'b1;

    always_comb begin
        fs_d     = fs_q;
        tmr_load = 1'b0;
        tmr_idx  = fs_q.ph;
        if (cmd_off) begin
            fs_d.mode    = MODE_IDLE;
            fs_d.up_done = 1'b0;
            fs_d.dn_done = 1'b0;
        end else begin
            unique case (fs_q.mode)
                MODE_IDLE: begin
                    if (cmd_up) begin
                        fs_d.mode    = MODE_UP;
                        fs_d.ph      = '0;
                        fs_d.stg[0]  = 1'b1;
                        fs_d.up_done = 1'b0;
                        fs_d.dn_done = 1'b0;
                        tmr_load     = 1'b1;
                        tmr_idx      = '0;
                    end else if (cmd_dn) begin
                        fs_d.mode          = MODE_DOWN;
                        fs_d.ph            = LAST_PH;
                        fs_d.stg[LAST_PH]  = 1'b0;
                        fs_d.up_done       = 1'b0;
                        fs_d.dn_done       = 1'b0;
                        tmr_load           = 1'b1;
                        tmr_idx            = LAST_PH;
                    end
                end
                MODE_UP: begin
                    if (expired) begin
                        if (fs_q.ph == LAST_PH) begin
                            fs_d.mode    = MODE_IDLE;
                            fs_d.up_done = 1'b1;
                        end else begin
                            fs_d.ph          = ph_inc;
                            fs_d.stg[ph_inc] = 1'b1;
                            tmr_load         = 1'b1;
                            tmr_idx          = ph_inc;
                        end
                    end
                end
                MODE_DOWN: begin
                    if (expired) begin
                        if (fs_q.ph == '0) begin
                            fs_d.mode    = MODE_IDLE;
                            fs_d.dn_done = 1'b1;
                        end else begin
                            fs_d.ph          = ph_dec;
                            fs_d.stg[ph_dec] = 1'b0;
                            tmr_load         = 1'b1;
                            tmr_idx          = ph_dec;
                        end
                    end
                end
                default: fs_d.mode = MODE_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fs_q <= '{mode: MODE_IDLE, ph: '0, stg: '0, up_done: 1'b0, dn_done: 1'b0};
        else        fs_q <= fs_d;
    end

    assign stage_en  = fs_q.stg;
    assign busy      = (fs_q.mode != MODE_IDLE);
    assign up_done   = fs_q.up_done;
    assign down_done = fs_q.dn_done;
endmodule

// File: rtl/fuse_supply_seq.sv
module fuse_supply_seq
    import fss_pkg::*;
#(
    parameter int NUM_PH = 3,
    parameter int DLY_W  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NUM_PH-1:0] stage_en,
    output logic              busy,
    output logic              up_done,
    output logic              down_done
);
    localparam int PH_W = (NUM_PH > 1) ? $clog2(NUM_PH) : 1;

    logic [NUM_PH-1:0][DLY_W-1:0] dly;
    logic                         cmd_up, cmd_dn, cmd_off;
    logic                         tmr_load, expired;
    logic [PH_W-1:0]              tmr_idx;
    logic [DLY_W-1:0]             load_val;

    fss_regs #(
        .NUM_PH(NUM_PH), .DLY_W(DLY_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .dly(dly), .cmd_up(cmd_up), .cmd_dn(cmd_dn), .cmd_off(cmd_off)
    );

    assign load_val = dly[tmr_idx];

    fss_timer #(.DLY_W(DLY_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(load_val), .expired(expired)
    );

    fss_fsm #(.NUM_PH(NUM_PH), .PH_W(PH_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_up(cmd_up), .cmd_dn(cmd_dn), .cmd_off(cmd_off),
        .expired(expired), .tmr_load(tmr_load), .tmr_idx(tmr_idx), .stage_en(stage_en),
        .busy(busy), .up_done(up_done), .down_done(down_done)
    );
endmodule

// File: rtl/fss_chk.sv
module fss_chk #(
    parameter int NUM_PH = 3,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2,
    parameter int CTRL_ADDR = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [NUM_PH-1:0] stage_en,
    input logic              busy,
    input logic              up_done,
    input logic              down_done
);
    logic ctl_wr;
    assign ctl_wr = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));

    for (genvar i = 0; i < NUM_PH - 1; i++) begin : g_order
        assert_stage_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
            stage_en[i+1] |-> stage_en[i]);
    end

    assert_up_complete_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up_done) |-> (&stage_en && !busy));

    assert_down_complete_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(down_done) |-> (stage_en == '0 && !busy));

    assert_done_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_done && down_done));

    assert_no_enable_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ctl_wr && !wr_data[0] && (wr_data[1] || wr_data[2]))
        |=> (!busy && $stable(stage_en) && $stable(up_done) && $stable(down_done)));

    assert_off_aborts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wr_data[2:0] == 3'b000)
        |=> (!busy && !up_done && !down_done && $stable(stage_en)));
endmodule

bind fuse_supply_seq fss_chk #(
    .NUM_PH(NUM_PH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_ADDR(2)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .stage_en(stage_en), .busy(busy), .up_done(up_done), .down_done(down_done)
);

// File: tb/sim_fuse_supply_seq.sv
`timescale 1ns/1ps
module sim_fuse_supply_seq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [31:0] wr_data;
    logic [2:0]  stage_en;
    logic        busy, up_done, down_done;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fuse_supply_seq u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .stage_en(stage_en), .busy(busy), .up_done(up_done), .down_done(down_done)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // called at a falling edge; returns at the falling edge after the write edge
    task automatic wr(logic [1:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_delays(int d0, int d1, int d2, logic [15:0] junk);
        wr(2'd0, {d1[15:0], d0[15:0]});
        wr(2'd1, {junk, d2[15:0]});
    endtask

    function automatic logic [2:0] exp_stage(bit up, logic [2:0] start, int k, int d0, int d1, int d2);
        if (up) return start | {k >= d0 + d1 + 2, k >= d0 + 1, 1'b1};
        else    return start & ~{1'b1, k >= d2 + 1, k >= d2 + d1 + 2};
    endfunction

    // runs one sequence from idle; inj_k >= 0 injects a control write mid-sequence (R10)
    task automatic run_seq(bit up, logic [2:0] cmd, int d0, int d1, int d2,
                           int inj_k, logic [2:0] inj_cmd);
        logic [2:0] start;
        int total;
        string sreq;
        string dreq;
        start = stage_en;
        total = d0 + d1 + d2 + 3;
        sreq  = up ? "R3 R2 R9" : "R5 R2 R9";
        dreq  = up ? "R4" : "R5";
        wr(2'd2, {29'd0, cmd});
        for (int k = 0; k <= total + 1; k++) begin
            chk(sreq, "stage_en", 32'(stage_en), 32'(exp_stage(up, start, k, d0, d1, d2)));
            chk(dreq, "done", 32'(up ? up_done : down_done), 32'(k >= total));
            chk("R6", "opposite done", 32'(up ? down_done : up_done), 32'd0);
            chk(inj_k >= 0 ? "R10 busy" : "R4 busy", "busy", 32'(busy), 32'(k < total));
            if (k == inj_k) begin
                wr_en = 1'b1; wr_addr = 2'd2; wr_data = {29'd0, inj_cmd};
            end
            @(negedge clk);
            wr_en = 1'b0;
        end
    endtask

    task automatic check_idle_hold(string req, int n, logic [2:0] st, bit ud, bit dd);
        for (int i = 0; i < n; i++) begin
            chk(req, "stage_en", 32'(stage_en), 32'(st));
            chk(req, "busy", 32'(busy), 32'd0);
            chk(req, "up_done", 32'(up_done), 32'(ud));
            chk(req, "down_done", 32'(down_done), 32'(dd));
            @(negedge clk);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int d0, d1, d2, tot;
        void'($urandom(32'h00c0ffee));
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_idle_hold("R1", 2, 3'b000, 1'b0, 1'b0);

        // R7: begin or stop without enable, R2: delay writes start nothing
        wr(2'd2, 32'h2);
        check_idle_hold("R7", 3, 3'b000, 1'b0, 1'b0);
        wr(2'd2, 32'h4);
        check_idle_hold("R7", 3, 3'b000, 1'b0, 1'b0);
        set_delays(0, 0, 0, 16'hffff);
        check_idle_hold("R2", 2, 3'b000, 1'b0, 1'b0);

        // R9: all-zero delays, one cycle per step
        run_seq(1'b1, 3'b011, 0, 0, 0, -1, 3'b000);
        wr(2'd2, 32'h4);
        check_idle_hold("R7", 3, 3'b111, 1'b1, 1'b0);
        run_seq(1'b0, 3'b101, 0, 0, 0, -1, 3'b000);

        // R2 packing with junk in the unused half; R10 begin wins over stop
        set_delays(5, 2, 9, 16'h1234);
        run_seq(1'b1, 3'b111, 5, 2, 9, 3, 3'b101);
        // R8: zero control when idle clears the done flag and holds the stages
        wr(2'd2, 32'h0);
        check_idle_hold("R8", 3, 3'b111, 1'b0, 1'b0);

        // R8: abort mid power-down
        set_delays(5, 5, 5, 16'h0);
        wr(2'd2, 32'h5);
        @(negedge clk); // k=1
        wr(2'd2, 32'h0); // edge at k=2 applies the abort
        check_idle_hold("R8", 10, 3'b011, 1'b0, 1'b0);
        // finish the power-up from the partial state
        run_seq(1'b1, 3'b011, 5, 5, 5, -1, 3'b000);

        // long steps
        set_delays(300, 1, 200, 16'h0);
        run_seq(1'b0, 3'b101, 300, 1, 200, 100, 3'b011);
        run_seq(1'b1, 3'b011, 300, 1, 200, -1, 3'b000);

        // random delays with mid-sequence injected commands (R10)
        for (int it = 0; it < 25; it++) begin
            d0 = int'($urandom_range(0, 12));
            d1 = int'($urandom_range(0, 12));
            d2 = int'($urandom_range(0, 12));
            tot = d0 + d1 + d2 + 3;
            set_delays(d0, d1, d2, 16'($urandom));
            run_seq(1'b0, 3'b101, d0, d1, d2, int'($urandom_range(0, tot - 1)), 3'b011);
            run_seq(1'b1, 3'b011, d0, d1, d2, int'($urandom_range(0, tot - 1)), 3'b111);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule